// File: doc/BRIEF.md
# Wavefront Dispatch Scheduler

This block sits between a dependency-check stage and the execution units of a SIMD compute cluster. For every execution resource it receives a vector of ready wavefronts. Each cycle it picks at most one of those waves and parks it in a one-entry waiting entry for that resource. The wave stays there while operands are gathered, then moves into a one-entry dispatch slot that the execution unit drains with a valid/ready handshake.

Selection is either oldest-first, using per-wave sequence stamps drawn from a global issue counter, or round-robin, using a rotating pointer kept per resource. Resources are numbered in a fixed order: vector ALUs first, then scalar ALUs, then the global-memory pipe, the local-memory pipe and the scalar-memory pipe. When the local-memory wave loses local-memory/flat arbitration, it is pulled back out of its dispatch slot and put into the waiting entry again. The operand collector, the register-file capacity check and the execution units are modelled only as handshake inputs.

Top module: `wds_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, every waiting entry and every dispatch slot is empty, so wait_valid_o and disp_valid_o are all zero.
- R2: A ready wave enters resource r's waiting entry on the next clock edge only if rf_ok_i[r] is high and that entry is empty. When rf_ok_i[r] is low, the entry stays empty.
- R3: With policy_i = 0 (oldest-first), the wave with the smallest sequence stamp wins. Each stamp_valid_i pulse gives wave stamp_wave_i the current value of a global counter, which then increments and starts at 0 after reset. On a tie, the lowest wave index wins.
- R4: With policy_i = 1 (round-robin), the search starts at the resource's pointer and wraps. The pointer resets to 0, moves to one past the granted wave on each grant, and stays unchanged on cycles with no grant.
- R5: A waiting wave moves to the dispatch slot only when opnd_rdy_i[r] is high and the slot is empty or being accepted in the same cycle. Otherwise the wave remains in the waiting entry unchanged.
- R6: A dispatch slot keeps its wave until disp_valid_o[r] and exe_ready_i[r] are both high. It is then refilled from the waiting entry in that same edge if R5 allows, or emptied otherwise.
- R7: The local-memory pipe is resource N_VALU+N_SALU+1, which is index 4 by default. While lm_lose_i is high and that slot holds a wave, disp_valid_o for the slot is low. On the next edge the wave returns to the waiting entry and the slot empties. lm_lose_i has no effect on any other resource.
- R8: The local-memory resource takes no new wave into its waiting entry while its dispatch slot is occupied.
- R9: A wave held in any waiting entry or dispatch slot is not selected again. When one wave is ready for several resources in the same cycle, the lowest resource index takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_i | input | 1 | 0 = oldest-first, 1 = round-robin |
| stamp_valid_i | input | 1 | Assign the next sequence stamp to stamp_wave_i |
| stamp_wave_i | input | WID_W (3) | Wave receiving the stamp |
| ready_i | input | NUM_RES*NUM_WAVES (48) | Per-resource ready vectors; bits [r*NUM_WAVES +: NUM_WAVES] belong to resource r |
| rf_ok_i | input | NUM_RES (6) | Register file can take a new wave for resource r |
| opnd_rdy_i | input | NUM_RES (6) | Operands gathered for the waiting wave of resource r |
| exe_ready_i | input | NUM_RES (6) | Execution unit r accepts its dispatch slot |
| lm_lose_i | input | 1 | Local-memory wave lost local-memory/flat arbitration |
| wait_valid_o | output | NUM_RES (6) | Waiting entry of resource r is occupied |
| wait_wave_o | output | NUM_RES*WID_W (18) | Wave in the waiting entry, slice r |
| disp_valid_o | output | NUM_RES (6) | Dispatch slot of resource r presented to its unit |
| disp_wave_o | output | NUM_RES*WID_W (18) | Wave in the dispatch slot, slice r |

## Verification
The hardest situation to reach is a local-memory push-back that lands at a defined moment. The wave must already be sitting in the dispatch slot with the execution unit holding ready low, and a second local-memory wave must be ready at the same time, so that the selection block (R8) and the return path (R7) are both visible. The stimulus gets there by holding exe_ready_i low and opnd_rdy_i high until the slot fills. It then presents the second ready wave for a cycle, and only after that raises lm_lose_i together with exe_ready_i. This shows that the loss overrides the accept. The round-robin wrap is reached by letting waves flow freely, so that a single resource grants three waves in turn. Grants are then withheld for several cycles to show that the pointer holds.

// File: rtl/wds_pkg.sv
package wds_pkg;

    typedef enum logic {
        POL_OLDEST = 1'b0,
        POL_RR     = 1'b1
    } pol_e;

    // Resource numbering: vector ALUs, scalar ALUs, global mem, local mem, scalar mem
    function automatic int res_count(int n_valu, int n_salu);
        return n_valu + n_salu + 3;
    endfunction

    function automatic int res_lm(int n_valu, int n_salu);
        return n_valu + n_salu + 1;
    endfunction

endpackage

// File: rtl/wds_pick.sv
module wds_pick #(
    parameter int NW    = 8,
    parameter int SEQ_W = 8,
    parameter int IW    = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  wds_pkg::pol_e       policy_i,
    input  logic                en_i,
    input  logic [NW-1:0]       cand_i,
    input  logic [NW*SEQ_W-1:0] seq_i,
    output logic                gnt_o,
    output logic [IW-1:0]       gnt_idx_o
);
    logic [IW-1:0]    ptr_q;
    logic [IW-1:0]    old_idx, rr_idx;
    logic [SEQ_W-1:0] old_seq;
    logic             old_found, rr_found;
    int               j;

    always_comb begin
        old_found = 1'b0;
        old_idx   = '0;
        old_seq   = '0;
        for (int i = 0; i < NW; i++) begin
            if (cand_i[i] && (!old_found || seq_i[i*SEQ_W +: SEQ_W] < old_seq)) begin
                old_found = 1'b1;
                old_idx   = IW'(i);
                old_seq   = seq_i[i*SEQ_W +: SEQ_W];
            end
        end
        rr_found = 1'b0;
        rr_idx   = '0;
        j        = 0;
        for (int k = 0; k < NW; k++) begin
            j = int'(ptr_q) + k;
            if (j >= NW) j = j - NW;
            if (!rr_found && cand_i[j]) begin
                rr_found = 1'b1;
                rr_idx   = IW'(j);
            end
        end
    end

    assign gnt_o     = en_i && (|cand_i);
    assign gnt_idx_o = (policy_i == wds_pkg::POL_RR) ? rr_idx : old_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (gnt_o) begin
            ptr_q <= (gnt_idx_o == IW'(NW-1)) ? '0 : gnt_idx_o + IW'(1);
        end
    end

    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !gnt_o |=> $stable(ptr_q));

    // R9
    gnt_cand_chk: assert property (@(posedge clk) disable iff (rst)
        gnt_o |-> cand_i[gnt_idx_o]);

endmodule

// File: rtl/wds_lane.sv
module wds_lane #(
    parameter int NW    = 8,
    parameter int IW    = 3,
    parameter bit IS_LM = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_i,
    input  logic [IW-1:0] sel_wave_i,
    input  logic          opnd_rdy_i,
    input  logic          exe_ready_i,
    input  logic          lose_i,
    output logic          take_ok_o,
    output logic          wait_v_o,
    output logic [IW-1:0] wait_wave_o,
    output logic          disp_v_o,
    output logic [IW-1:0] disp_wave_o,
    output logic [NW-1:0] occ_o
);
    typedef struct packed {
        logic          v;
        logic [IW-1:0] w;
    } slot_t;

    slot_t wait_q, disp_q;
    logic  lose, fire, move;

    assign lose      = IS_LM ? lose_i : 1'b0;
    assign disp_v_o  = disp_q.v && !lose;
    assign fire      = disp_v_o && exe_ready_i;
    assign move      = wait_q.v && opnd_rdy_i && (!disp_q.v || fire);
    assign take_ok_o = !wait_q.v && (IS_LM ? !disp_q.v : 1'b1);

    assign wait_v_o    = wait_q.v;
    assign wait_wave_o = wait_q.w;
    assign disp_wave_o = disp_q.w;

    always_comb begin
        occ_o = '0;
        if (wait_q.v) occ_o[wait_q.w] = 1'b1;
        if (disp_q.v) occ_o[disp_q.w] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= '0;
            disp_q <= '0;
        end else if (lose && disp_q.v) begin
            wait_q <= disp_q;
            disp_q <= '0;
        end else begin
            if (move)      disp_q <= wait_q;
            else if (fire) disp_q <= '0;
            if (sel_i)     wait_q <= '{v: 1'b1, w: sel_wave_i};
            else if (move) wait_q <= '0;
        end
    end

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wait_q.v && !opnd_rdy_i |=> wait_q.v && $stable(wait_q.w));

    // R6
    disp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        disp_v_o && !exe_ready_i |=> disp_q.v && $stable(disp_q.w));

    if (IS_LM) begin : g_lm
        // R7
        lose_back_chk: assert property (@(posedge clk) disable iff (rst)
            lose_i && disp_q.v |=> wait_q.v && !disp_q.v && wait_q.w == $past(disp_q.w));
        // R8
        lm_excl_chk: assert property (@(posedge clk) disable iff (rst)
            disp_q.v |-> !wait_q.v);
    end

endmodule

// File: rtl/wds_top.sv
module wds_top #(
    parameter int NUM_WAVES = 8,
    parameter int N_VALU    = 2,
    parameter int N_SALU    = 1,
    parameter int SEQ_W     = 8,
    localparam int NUM_RES  = wds_pkg::res_count(N_VALU, N_SALU),
    localparam int WID_W    = $clog2(NUM_WAVES)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         policy_i,
    input  logic                         stamp_valid_i,
    input  logic [WID_W-1:0]             stamp_wave_i,
    input  logic [NUM_RES*NUM_WAVES-1:0] ready_i,
    input  logic [NUM_RES-1:0]           rf_ok_i,
    input  logic [NUM_RES-1:0]           opnd_rdy_i,
    input  logic [NUM_RES-1:0]           exe_ready_i,
    input  logic                         lm_lose_i,
    output logic [NUM_RES-1:0]           wait_valid_o,
    output logic [NUM_RES*WID_W-1:0]     wait_wave_o,
    output logic [NUM_RES-1:0]           disp_valid_o,
    output logic [NUM_RES*WID_W-1:0]     disp_wave_o
);
    localparam int RES_LM = wds_pkg::res_lm(N_VALU, N_SALU);
    localparam int NW     = NUM_WAVES;

    logic [NW*SEQ_W-1:0]       seq_q;
    logic [SEQ_W-1:0]          gctr_q;
    logic [NUM_RES*NW-1:0]     occ_flat;
    logic [(NUM_RES+1)*NW-1:0] taken_chain;
    logic [NW-1:0]             busy;
    logic [NUM_RES-1:0]        wocc [NW];
    wds_pkg::pol_e             pol;

    assign pol = wds_pkg::pol_e'(policy_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q  <= '0;
            gctr_q <= '0;
        end else if (stamp_valid_i) begin
            seq_q[stamp_wave_i*SEQ_W +: SEQ_W] <= gctr_q;
            gctr_q <= gctr_q + SEQ_W'(1);
        end
    end

    always_comb begin
        busy = '0;
        for (int r = 0; r < NUM_RES; r++) busy = busy | occ_flat[r*NW +: NW];
        for (int w = 0; w < NW; w++)
            for (int r = 0; r < NUM_RES; r++) wocc[w][r] = occ_flat[r*NW + w];
    end

    assign taken_chain[NW-1:0] = '0;

    for (genvar r = 0; r < NUM_RES; r++) begin : g_res
        logic [NW-1:0]    cand, prev, mine;
        logic             take_ok, en, gnt;
        logic [WID_W-1:0] gidx;

        assign prev = taken_chain[r*NW +: NW];
        assign cand = ready_i[r*NW +: NW] & ~busy & ~prev;
        assign en   = take_ok && rf_ok_i[r];
        assign mine = gnt ? (NW'(1) << gidx) : '0;
        assign taken_chain[(r+1)*NW +: NW] = prev | mine;

        wds_pick #(.NW(NW), .SEQ_W(SEQ_W), .IW(WID_W)) u_pick (
            .clk       (clk),
            .rst       (rst),
            .policy_i  (pol),
            .en_i      (en),
            .cand_i    (cand),
            .seq_i     (seq_q),
            .gnt_o     (gnt),
            .gnt_idx_o (gidx)
        );

        wds_lane #(.NW(NW), .IW(WID_W), .IS_LM(r == RES_LM)) u_lane (
            .clk         (clk),
            .rst         (rst),
            .sel_i       (gnt),
            .sel_wave_i  (gidx),
            .opnd_rdy_i  (opnd_rdy_i[r]),
            .exe_ready_i (exe_ready_i[r]),
            .lose_i      (lm_lose_i),
            .take_ok_o   (take_ok),
            .wait_v_o    (wait_valid_o[r]),
            .wait_wave_o (wait_wave_o[r*WID_W +: WID_W]),
            .disp_v_o    (disp_valid_o[r]),
            .disp_wave_o (disp_wave_o[r*WID_W +: WID_W]),
            .occ_o       (occ_flat[r*NW +: NW])
        );
    end

    // R3
    stamp_adv_chk: assert property (@(posedge clk) disable iff (rst)
        stamp_valid_i |=> gctr_q == $past(gctr_q) + SEQ_W'(1));

    for (genvar w = 0; w < NW; w++) begin : g_wchk
        // R9
        one_slot_chk: assert property (@(posedge clk) disable iff (rst)
            $countones(wocc[w]) <= 1);
    end

endmodule

// File: tb/sim_wds_top.sv
`timescale 1ns/1ps
module sim_wds_top;
    localparam int NW = 8;
    localparam int NR = 6;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          policy;
    logic          stamp_valid;
    logic [IW-1:0] stamp_wave;
    logic [NR*NW-1:0] ready;
    logic [NR-1:0] rf_ok, opnd_rdy, exe_ready;
    logic          lm_lose;
    logic [NR-1:0] wait_valid, disp_valid;
    logic [NR*IW-1:0] wait_wave, disp_wave;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wds_top u0 (
        .clk(clk), .rst(rst), .policy_i(policy),
        .stamp_valid_i(stamp_valid), .stamp_wave_i(stamp_wave),
        .ready_i(ready), .rf_ok_i(rf_ok), .opnd_rdy_i(opnd_rdy),
        .exe_ready_i(exe_ready), .lm_lose_i(lm_lose),
        .wait_valid_o(wait_valid), .wait_wave_o(wait_wave),
        .disp_valid_o(disp_valid), .disp_wave_o(disp_wave)
    );

    function automatic int ww(int r); return int'(wait_wave[r*IW +: IW]); endfunction
    function automatic int dw(int r); return int'(disp_wave[r*IW +: IW]); endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic clear_in;
        policy = 1'b0; stamp_valid = 1'b0; stamp_wave = '0; ready = '0;
        rf_ok = '0; opnd_rdy = '0; exe_ready = '0; lm_lose = 1'b0;
    endtask

    task automatic do_reset;
        clear_in;
        rst = 1'b1;
        tick; tick;
        rst = 1'b0;
    endtask

    task automatic stamp(input int w);
        stamp_valid = 1'b1; stamp_wave = IW'(w);
        tick;
        stamp_valid = 1'b0;
    endtask

    task automatic t_reset;
        clear_in;
        rst = 1'b1;
        tick; tick;
        chk(wait_valid == '0, "R1 wait empty in reset", int'(wait_valid), 0);
        chk(disp_valid == '0, "R1 disp empty in reset", int'(disp_valid), 0);
        rst = 1'b0;
        tick;
        chk(wait_valid == '0 && disp_valid == '0, "R1 empty after reset",
            int'({wait_valid, disp_valid}), 0);
    endtask

    task automatic t_oldest;
        do_reset;
        stamp(3); stamp(1); stamp(6); stamp(0); stamp(2); stamp(4); stamp(5); stamp(7);
        ready[0*NW +: NW] = 8'b0100_0011;
        ready[1*NW +: NW] = 8'b0000_0001;
        rf_ok = 6'b000001;
        tick;
        chk(wait_valid[0] && ww(0) == 1, "R3 oldest stamp wins", ww(0), 1);
        chk(!wait_valid[1], "R2 rf_ok low blocks entry", int'(wait_valid[1]), 0);
        tick;
        chk(wait_valid[0] && ww(0) == 1, "R5 waiting wave held", ww(0), 1);
        do_reset;
        ready[0*NW +: NW] = 8'b1010_0100;
        rf_ok = 6'b000001;
        tick;
        chk(wait_valid[0] && ww(0) == 2, "R3 tie lowest index", ww(0), 2);
    endtask

    task automatic t_rr;
        int got [4];
        int n = 0;
        do_reset;
        policy = 1'b1;
        ready[2*NW +: NW] = 8'b0101_0010;
        rf_ok[2] = 1'b1; opnd_rdy[2] = 1'b1; exe_ready[2] = 1'b1;
        for (int c = 0; c < 16 && n < 4; c++) begin
            tick;
            if (wait_valid[2]) begin got[n] = ww(2); n++; end
        end
        chk(n == 4, "R4 four grants seen", n, 4);
        chk(got[0] == 1, "R4 first grant", got[0], 1);
        chk(got[1] == 4, "R4 second grant", got[1], 4);
        chk(got[2] == 6, "R4 third grant", got[2], 6);
        chk(got[3] == 1, "R4 wrap grant", got[3], 1);
        rf_ok[2] = 1'b0;
        tick; tick; tick; tick;
        chk(!wait_valid[2], "R2 no entry with rf_ok low", int'(wait_valid[2]), 0);
        rf_ok[2] = 1'b1;
        tick;
        chk(wait_valid[2] && ww(2) == 4, "R4 pointer held while idle", ww(2), 4);
    endtask

    task automatic t_flow;
        do_reset;
        ready[0*NW +: NW] = 8'b0010_0100;
        rf_ok[0] = 1'b1;
        tick;
        chk(wait_valid[0] && ww(0) == 2, "R2 enters waiting entry", ww(0), 2);
        tick;
        chk(wait_valid[0] && !disp_valid[0], "R5 waits for operands",
            int'(disp_valid[0]), 0);
        opnd_rdy[0] = 1'b1;
        tick;
        chk(disp_valid[0] && dw(0) == 2 && !wait_valid[0], "R5 moves to dispatch", dw(0), 2);
        tick;
        chk(wait_valid[0] && ww(0) == 5, "R9 held wave skipped", ww(0), 5);
        lm_lose = 1'b1;
        tick;
        chk(wait_valid[0] && ww(0) == 5, "R5 held while slot busy", ww(0), 5);
        chk(disp_valid[0] && dw(0) == 2, "R6 slot held without ready", dw(0), 2);
        chk(disp_valid[0], "R7 lose ignored off local pipe", int'(disp_valid[0]), 1);
        lm_lose = 1'b0;
        exe_ready[0] = 1'b1;
        ready = '0;
        tick;
        chk(disp_valid[0] && dw(0) == 5 && !wait_valid[0], "R6 accept refills slot", dw(0), 5);
        tick;
        chk(!disp_valid[0], "R6 accept empties slot", int'(disp_valid[0]), 0);
    endtask

    task automatic t_lm;
        do_reset;
        ready[4*NW +: NW] = 8'b0000_1000;
        rf_ok[4] = 1'b1; opnd_rdy[4] = 1'b1;
        tick;
        chk(wait_valid[4] && ww(4) == 3, "R2 local wave enters", ww(4), 3);
        tick;
        chk(disp_valid[4] && dw(4) == 3, "R5 local wave dispatched", dw(4), 3);
        ready[4*NW +: NW] = 8'b0100_1000;
        tick;
        chk(!wait_valid[4], "R8 no entry while slot busy", int'(wait_valid[4]), 0);
        lm_lose = 1'b1; exe_ready[4] = 1'b1;
        ready = '0;
        #1;
        chk(!disp_valid[4], "R7 valid dropped on loss", int'(disp_valid[4]), 0);
        tick;
        chk(wait_valid[4] && ww(4) == 3 && !disp_valid[4], "R7 wave pushed back", ww(4), 3);
        lm_lose = 1'b0;
        tick;
        chk(disp_valid[4] && dw(4) == 3, "R7 redispatch after loss", dw(4), 3);
        tick;
        chk(!disp_valid[4] && !wait_valid[4], "R6 local accept empties", int'(disp_valid[4]), 0);
    endtask

    task automatic t_claim;
        do_reset;
        ready[1*NW +: NW] = 8'b0010_0000;
        ready[3*NW +: NW] = 8'b0010_0000;
        rf_ok = '1;
        tick;
        chk(wait_valid[1] && ww(1) == 5, "R9 lower resource claims", ww(1), 5);
        chk(!wait_valid[3], "R9 higher resource skipped", int'(wait_valid[3]), 0);
        tick;
        chk(!wait_valid[3], "R9 busy wave not reselected", int'(wait_valid[3]), 0);
    endtask

    initial begin
        clear_in;
        t_reset;
        t_oldest;
        t_rr;
        t_flow;
        t_lm;
        t_claim;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule